// File: doc/BRIEF.md
# Circular Buffer Streamer

This block feeds a waveform generator from memory without processor help. It reads a buffer of 32-bit words from a simple memory read port and pushes each word into a FIFO write port. Every word waits for the FIFO's data request. Once the whole buffer has gone out, a one-cycle control step copies the stored buffer pointer back into the read address and reloads the word counter. The stream then starts again from the top, and it keeps looping until it is stopped or reprogrammed.

Software, or a neighbouring block, supplies a base word address and a length, then pulses a start strobe. A new start at any time reprograms the pointer and the length and restarts the loop from the new base. A stop strobe ends the stream at the next word boundary. The busy output tells the owner whether the stream is running.

Top module: `ring_streamer`

## Requirements
- R1: While reset is held, and afterwards until the first start, busy, memRdEn and fifoWrEn are all low.
- R2: After a start with a nonzero length L, reads go to word addresses base, base+1, ..., base+L-1 (one step per word). Each FIFO word is the memory word read on the previous cycle.
- R3: A memory read is issued only in a cycle in which fifoReq is high. While fifoReq stays low, a running stream issues no reads and no FIFO writes, and busy stays high.
- R4: After the L-th word of a block, a single control cycle reloads the read address to base and the count to L. The sequence then repeats without end. With fifoReq held high, word k+L is written exactly 2L+1 cycles after word k.
- R5: Every memory read is followed on the next cycle by exactly one FIFO write (unless a start arrives in that cycle). No FIFO write occurs without a read on the cycle before.
- R6: A start with length 0 leaves busy low on the next cycle and issues no reads or FIFO writes. This holds both from idle and while streaming.
- R7: A start while busy takes the new base and length. A word in flight in that cycle is dropped, and the next written word is the word at the new base.
- R8: A stop pulse ends the stream at the next word boundary. At most one more FIFO write follows the stop cycle, busy is low within two cycles, and no reads or writes occur afterwards.
- R9: Busy rises on the cycle after a start with nonzero length and stays high until a stop or a zero-length start takes effect.
- R10: A stop pulse while idle has no lasting effect. When start and stop arrive in the same cycle, the start wins and the stream runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgBase | input | ADDR_W | Buffer base word address, taken on cfgStart |
| cfgLen | input | LEN_W | Buffer length in words, taken on cfgStart |
| cfgStart | input | 1 | One-cycle strobe: load configuration and restart |
| stopReq | input | 1 | One-cycle strobe: halt at next word boundary |
| memRdEn | output | 1 | Memory read request |
| memAddr | output | ADDR_W | Memory word address |
| memRdData | input | DATA_W | Read data, valid the cycle after memRdEn |
| fifoReq | input | 1 | FIFO data request (space available) |
| fifoWrEn | output | 1 | FIFO write strobe |
| fifoWrData | output | DATA_W | FIFO write data |
| busy | output | 1 | Stream active |

## Verification
The hardest case to reach from the ports is a reconfiguration or stop that lands exactly on a word in flight. That is the cycle between a memory read and its FIFO write, and it is also where the loop sits inside its one-cycle reload step. The bench holds fifoReq high so that the stream settles into its fixed three-phase rhythm. It then fires start or stop at chosen write counts, which places the strobe on known phases. The data after the strobe is checked against words computed from the new base, which shows whether a dropped word leaked through. Separate vectors with lengths 1, 3, 4 and 7 run across several wraps, so that the reload step is hit back to back.

// File: rtl/ring_streamer_pkg.sv
package ring_streamer_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_RELOAD = 2'd1,
    PH_ISSUE  = 2'd2,
    PH_WRITE  = 2'd3
  } phase_e;

  typedef struct packed {
    logic loadCfg;
    logic reload;
    logic advance;
  } dpStrobe_t;

endpackage

// File: rtl/ring_streamer_dp.sv
module ring_streamer_dp
  import ring_streamer_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [LEN_W-1:0]  cfgLen,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              lastWord,
  output logic              cfgLenZero
);

  localparam logic [LEN_W-1:0]  LEN_ONE  = LEN_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] ptrReg;
  logic [LEN_W-1:0]  lenReg;
  logic [LEN_W-1:0]  remain;

  // stored pointer and length, written only by a start
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrReg <= '0;
      lenReg <= '0;
    end else if (strobe.loadCfg) begin
      ptrReg <= cfgBase;
      lenReg <= cfgLen;
    end
  end

  // working read address and word counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdAddr <= '0;
      remain <= '0;
    end else if (strobe.reload) begin
      rdAddr <= ptrReg;
      remain <= lenReg;
    end else if (strobe.advance) begin
      rdAddr <= rdAddr + ADDR_ONE;
      remain <= remain - LEN_ONE;
    end
  end

  assign lastWord   = (remain == LEN_ONE);
  assign cfgLenZero = (cfgLen == '0);

  // R4: control step restores pointer and count
  p_reload_restores_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.reload |=> (rdAddr == $past(ptrReg)) && (remain == $past(lenReg)));

  // R4: no word is moved once the count is used up
  p_advance_nonzero_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |-> (remain != '0));

  // R2: each moved word steps the address by one
  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |=> (rdAddr == $past(rdAddr) + ADDR_ONE));

endmodule

// File: rtl/ring_streamer_ctrl.sv
module ring_streamer_ctrl
  import ring_streamer_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cfgStart,
  input  logic      stopReq,
  input  logic      fifoReq,
  input  logic      cfgLenZero,
  input  logic      lastWord,
  output dpStrobe_t strobe,
  output logic      memRdEn,
  output logic      fifoWrEn,
  output logic      busy
);

  phase_e phase, phaseNext;
  logic   stopPending, stopPendingNext;
  logic   stopNow;

  assign stopNow = stopReq || stopPending;

  always_comb begin
    phaseNext = phase;
    strobe    = '0;
    memRdEn   = 1'b0;
    fifoWrEn  = 1'b0;
    if (cfgStart) begin
      strobe.loadCfg = 1'b1;
      phaseNext      = cfgLenZero ? PH_IDLE : PH_RELOAD;
    end else begin
      unique case (phase)
        PH_IDLE: phaseNext = PH_IDLE;
        PH_RELOAD: begin
          if (stopNow) begin
            phaseNext = PH_IDLE;
          end else begin
            strobe.reload = 1'b1;
            phaseNext     = PH_ISSUE;
          end
        end
        PH_ISSUE: begin
          if (stopNow) begin
            phaseNext = PH_IDLE;
          end else if (fifoReq) begin
            memRdEn   = 1'b1;
            phaseNext = PH_WRITE;
          end
        end
        PH_WRITE: begin
          fifoWrEn       = 1'b1;
          strobe.advance = 1'b1;
          phaseNext      = lastWord ? PH_RELOAD : PH_ISSUE;
        end
        default: phaseNext = PH_IDLE;
      endcase
    end
  end

  assign stopPendingNext = stopNow && !cfgStart && (phaseNext != PH_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase       <= PH_IDLE;
      stopPending <= 1'b0;
    end else begin
      phase       <= phaseNext;
      stopPending <= stopPendingNext;
    end
  end

  assign busy = (phase != PH_IDLE);

  // R1: an idle streamer touches neither port
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memRdEn && !fifoWrEn));

  // R3: reads only under a FIFO request
  p_read_paced_r3: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> fifoReq);

  // R5: a read is followed by its write unless a start intervenes
  p_read_then_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> (fifoWrEn || cfgStart));

  // R5: no write without the read before it
  p_write_has_read_r5: assert property (@(posedge clk) disable iff (!rstN)
    fifoWrEn |-> $past(memRdEn));

  // R6: zero length start leaves the streamer idle
  p_zero_len_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cfgStart && cfgLenZero) |=> !busy);

  // R9: nonzero start makes the streamer busy
  p_start_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cfgStart && !cfgLenZero) |=> busy);

  // R8: stop outside a write phase ends the stream at once
  p_stop_halts_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stopReq && !cfgStart && !fifoWrEn) |=> !busy);

endmodule

// File: rtl/ring_streamer.sv
module ring_streamer
  import ring_streamer_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [LEN_W-1:0]  cfgLen,
  input  logic              cfgStart,
  input  logic              stopReq,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memRdData,
  input  logic              fifoReq,
  output logic              fifoWrEn,
  output logic [DATA_W-1:0] fifoWrData,
  output logic              busy
);

  dpStrobe_t strobe;
  logic      lastWord;
  logic      cfgLenZero;

  ring_streamer_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgStart   (cfgStart),
    .stopReq    (stopReq),
    .fifoReq    (fifoReq),
    .cfgLenZero (cfgLenZero),
    .lastWord   (lastWord),
    .strobe     (strobe),
    .memRdEn    (memRdEn),
    .fifoWrEn   (fifoWrEn),
    .busy       (busy)
  );

  ring_streamer_dp #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cfgBase    (cfgBase),
    .cfgLen     (cfgLen),
    .rdAddr     (memAddr),
    .lastWord   (lastWord),
    .cfgLenZero (cfgLenZero)
  );

  assign fifoWrData = memRdData;

endmodule

// File: tb/ring_streamer_test.sv
module ring_streamer_test;

  localparam int AW = 16;
  localparam int LW = 16;
  localparam int DW = 32;
  localparam int CAP = 512;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] cfgBase = '0;
  logic [LW-1:0] cfgLen = '0;
  logic          cfgStart = 1'b0;
  logic          stopReq = 1'b0;
  logic          memRdEn;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memRdData = '0;
  logic          fifoReq = 1'b0;
  logic          fifoWrEn;
  logic [DW-1:0] fifoWrData;
  logic          busy;

  int total = 0;
  int bad = 0;
  int cycle = 0;
  int capCnt = 0;
  int rdCnt = 0;
  logic [DW-1:0] capData [CAP];
  int            capCyc  [CAP];

  always #10 clk = ~clk;

  ring_streamer uut (
    .clk(clk), .rstN(rstN), .cfgBase(cfgBase), .cfgLen(cfgLen),
    .cfgStart(cfgStart), .stopReq(stopReq), .memRdEn(memRdEn),
    .memAddr(memAddr), .memRdData(memRdData), .fifoReq(fifoReq),
    .fifoWrEn(fifoWrEn), .fifoWrData(fifoWrData), .busy(busy)
  );

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return {a ^ 16'hA5C3, a};
  endfunction

  // memory model: one cycle read latency
  always @(posedge clk) begin
    cycle <= cycle + 1;
    if (memRdEn) memRdData <= pat(memAddr);
  end

  // monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (memRdEn) rdCnt++;
    if (fifoWrEn && capCnt < CAP) begin
      capData[capCnt] = fifoWrData;
      capCyc[capCnt]  = cycle;
      capCnt++;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic startCfg(input logic [AW-1:0] b, input logic [LW-1:0] l, input bit alsoStop);
    @(posedge clk); #2;
    cfgBase = b; cfgLen = l; cfgStart = 1'b1; stopReq = alsoStop;
    @(posedge clk); #2;
    cfgStart = 1'b0; stopReq = 1'b0;
  endtask

  task automatic stopPulse();
    @(posedge clk); #2;
    stopReq = 1'b1;
    @(posedge clk); #2;
    stopReq = 1'b0;
  endtask

  task automatic waitWrites(input int n);
    int guard = 0;
    while (capCnt < n && guard < 5000) begin
      @(posedge clk); guard++;
    end
    #2;
    chk(capCnt >= n, "R2 stream stalled", capCnt, n);
  endtask

  // base[47:32] len[31:16] words[15:0]
  localparam logic [47:0] VEC [4] = '{
    {16'h0100, 16'd4, 16'd10},
    {16'h0200, 16'd1, 16'd5},
    {16'h0300, 16'd7, 16'd16},
    {16'h1234, 16'd3, 16'd9}
  };

  initial begin
    #(20 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=%0d expected=0", cycle);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int mark, snap;
    logic [AW-1:0] b;
    int l, w;

    // R1 reset state
    cyc(3);
    @(negedge clk);
    chk(!busy && !memRdEn && !fifoWrEn, "R1 in reset", {busy, memRdEn, fifoWrEn}, 0);
    @(posedge clk); #2 rstN = 1'b1;
    cyc(4);
    chk(!busy && capCnt == 0 && rdCnt == 0, "R1 after reset", {busy, capCnt[7:0]}, 0);

    // table walk: R2, R4, R8
    for (int v = 0; v < 4; v++) begin
      b = VEC[v][47:32]; l = int'(VEC[v][31:16]); w = int'(VEC[v][15:0]);
      capCnt = 0; rdCnt = 0;
      fifoReq = 1'b1;
      startCfg(b, LW'(l), 1'b0);
      waitWrites(w);
      fifoReq = 1'b0;
      stopPulse();
      cyc(2);
      chk(!busy, "R8 busy after stop", busy, 0);
      for (int i = 0; i < capCnt; i++)
        chk(capData[i] == pat(b + AW'(i % l)), "R2 R4 word", capData[i], pat(b + AW'(i % l)));
      if (w > l)
        chk(capCyc[l] - capCyc[0] == 2 * l + 1, "R4 loop period",
            capCyc[l] - capCyc[0], 2 * l + 1);
    end

    // R3 pacing: no request, no traffic
    capCnt = 0; rdCnt = 0;
    fifoReq = 1'b0;
    startCfg(16'h0400, 16'd4, 1'b0);
    cyc(10);
    chk(busy, "R9 busy while starved", busy, 1);
    chk(rdCnt == 0 && capCnt == 0, "R3 no traffic without request", rdCnt + capCnt, 0);
    @(posedge clk); #2 fifoReq = 1'b1;
    @(posedge clk); #2 fifoReq = 1'b0;
    cyc(10);
    chk(capCnt == 1 && rdCnt == 1, "R3 one request one word", capCnt, 1);
    chk(capData[0] == pat(16'h0400), "R5 word follows read", capData[0], pat(16'h0400));

    // R6 zero length while busy, then from idle
    snap = capCnt;
    startCfg(16'h0500, 16'd0, 1'b0);
    @(negedge clk);
    chk(!busy, "R6 zero length stops", busy, 0);
    fifoReq = 1'b1;
    rdCnt = 0;
    startCfg(16'h0500, 16'd0, 1'b0);
    cyc(10);
    chk(!busy && rdCnt == 0 && capCnt == snap, "R6 zero length from idle", rdCnt, 0);

    // R7 restart mid-stream
    capCnt = 0;
    startCfg(16'h0600, 16'd3, 1'b0);
    waitWrites(4);
    @(posedge clk); #2;
    cfgBase = 16'h0700; cfgLen = 16'd2; cfgStart = 1'b1;
    mark = capCnt;
    @(posedge clk); #2 cfgStart = 1'b0;
    waitWrites(mark + 4);
    for (int i = 0; i < 4; i++)
      chk(capData[mark + i] == pat(16'h0700 + AW'(i % 2)), "R7 restart word",
          capData[mark + i], pat(16'h0700 + AW'(i % 2)));

    // R8 stop with request still high
    @(posedge clk); #2 stopReq = 1'b1;
    snap = capCnt;
    @(posedge clk); #2 stopReq = 1'b0;
    cyc(1);
    chk(!busy, "R8 halts within two cycles", busy, 0);
    cyc(10);
    chk(capCnt - snap <= 1, "R8 at most one trailing word", capCnt - snap, 1);
    snap = capCnt; rdCnt = 0;
    cyc(10);
    chk(capCnt == snap && rdCnt == 0, "R8 quiet after stop", rdCnt, 0);

    // R10 stop while idle, then start together with stop
    stopPulse();
    cyc(3);
    capCnt = 0;
    startCfg(16'h0800, 16'd2, 1'b1);
    cyc(8);
    chk(busy && capCnt > 0, "R10 start beats stop", capCnt, 1);
    chk(capData[0] == pat(16'h0800), "R10 first word", capData[0], pat(16'h0800));
    fifoReq = 1'b0;
    stopPulse();
    cyc(3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule